// File: doc/BRIEF.md
# Key Matrix Scanner with Serial Code Link

The block scans a key matrix and reports every key change as an 8-bit code to a host. One strobe line is raised at a time, and the scanner steps through all eleven strobes in a fixed rotation. One full pass takes 6 ms at the default divider setting. At the end of each strobe's dwell time, the scanner samples the eight sense lines and compares them with the state it last reported for that strobe. Sense lines are active high, meaning the key is pressed. There is no debounce.

The scanner reports at most one difference per dwell: the changed sense line with the lowest index. It packs that change into a code and hands the code to a serial transmitter. The transmitter sends the code least significant bit first, with one clock pulse per bit. A receiver shift register on the host side rebuilds the byte and raises an interrupt. A host read strobe clears the interrupt. If a second code lands before the host reads, it replaces the held byte and sets an overrun flag.

Top module: `kbd_scan_link`

## Requirements
- R1: After reset, strobe 0 alone is high, the serial clock and data lines are low, and the interrupt and overrun outputs are low.
- R2: Exactly one strobe is high at any time. Each strobe stays high for STEP_DIV clocks. Strobes advance 0,1,…,10 and then wrap to 0, so one full pass takes 11·STEP_DIV clocks.
- R3: A key press on strobe s, sense line k produces code = {1'b0, s[3:0], k[2:0]}. Bit 7 is 0, bits 6:3 hold the strobe index and bits 2:0 hold the sense index.
- R4: A key release produces the same code with bit 7 set to 1.
- R5: Each code goes out as 8 bits, least significant first. The data line changes only while the serial clock is low. The receiver samples each bit on the rising clock edge.
- R6: After the 8th bit, the interrupt goes high and the received-byte output equals the code that was sent.
- R7: A pulse on the read strobe clears the interrupt on the next clock edge. A completing frame takes priority over a read in the same cycle.
- R8: When a frame completes while the interrupt is still high, the new byte replaces the old one and the overrun flag sets. A read clears the overrun flag.
- R9: When no sense line differs from its reported state, no serial frame is sent and the interrupt stays low.
- R10: When several sense lines change on one strobe, each change is reported in its own code, lowest sense index first. A change that the scanner sees while the transmitter is busy stays pending and is reported on a later pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_o | output | 11 | One-hot matrix strobe lines |
| sense_i | input | 8 | Matrix sense lines, 1 = key closed |
| ser_clk_o | output | 1 | Serial link clock |
| ser_data_o | output | 1 | Serial link data, LSB first |
| rd_i | input | 1 | Host read strobe, one clock wide |
| rx_byte_o | output | 8 | Last received key code |
| irq_o | output | 1 | Code-ready interrupt |
| overrun_o | output | 1 | Code replaced before it was read |

## Verification
A wrong strobe index or a broken divider shows on the strobe lines within one dwell. It also shows as a wrong strobe field in the next code. Stale per-strobe key memory shows up as a missing code, a repeated code or a code with the wrong bit 7 within one scan pass, about 11·STEP_DIV clocks. A fault in the transmitter or receiver shift registers shows as a byte mismatch at the interrupt, 16·TX_HALF clocks after the code is loaded. A fault in the interrupt or overrun flags shows within one clock of a read or of a frame completing.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
    localparam int CODE_W = 8;

    typedef struct packed {
        logic       rel;
        logic [3:0] strobe;
        logic [2:0] sense;
    } key_code_t;
endpackage

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan
    import kbd_scan_pkg::*;
#(
    parameter int N_STROBE = 11,
    parameter int N_SENSE  = 8,
    parameter int STEP_DIV = 109091
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SENSE-1:0]  sense_i,
    input  logic                tx_ready_i,
    output logic [N_STROBE-1:0] strobe_o,
    output logic                code_valid_o,
    output key_code_t           code_o
);
    localparam int IDX_W = $clog2(N_STROBE);
    localparam int POS_W = $clog2(N_SENSE);
    localparam int DIV_W = $clog2(STEP_DIV + 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [DIV_W-1:0] div;
    } scan_t;

    scan_t             st_d, st_q;
    logic [N_SENSE-1:0] seen_d [N_STROBE];
    logic [N_SENSE-1:0] seen_q [N_STROBE];
    logic [N_SENSE-1:0] diff;
    logic [POS_W-1:0]   pos;
    logic               found;
    logic               step_end;
    logic               emit;

    always_comb begin
        step_end = (st_q.div == DIV_W'(STEP_DIV - 1));
        diff     = sense_i ^ seen_q[st_q.idx];
        found    = 1'b0;
        pos      = '0;
        for (int k = N_SENSE - 1; k >= 0; k--) begin
            if (diff[k]) begin
                found = 1'b1;
                pos   = POS_W'(k);
            end
        end
        emit = step_end && found && tx_ready_i;

        st_d = st_q;
        if (step_end) begin
            st_d.div = '0;
            st_d.idx = (st_q.idx == IDX_W'(N_STROBE - 1)) ? '0 : st_q.idx + 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end

        for (int s = 0; s < N_STROBE; s++) seen_d[s] = seen_q[s];
        if (emit) seen_d[st_q.idx][pos] = sense_i[pos];

        code_o.rel    = ~sense_i[pos];
        code_o.strobe = 4'(st_q.idx);
        code_o.sense  = 3'(pos);
        code_valid_o  = emit;
        strobe_o      = N_STROBE'(1) << st_q.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int s = 0; s < N_STROBE; s++) seen_q[s] <= '0;
        end else begin
            st_q <= st_d;
            for (int s = 0; s < N_STROBE; s++) seen_q[s] <= seen_d[s];
        end
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strobe_o) == 1) else $error("strobe not one-hot"); // R2
    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_end |=> $stable(strobe_o)) else $error("strobe moved mid-dwell"); // R2
    AST_EMIT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |-> tx_ready_i) else $error("code offered to busy link"); // R10
endmodule

// File: rtl/kbd_serial_tx.sv
module kbd_serial_tx
    import kbd_scan_pkg::*;
#(
    parameter int TX_HALF = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  key_code_t code_i,
    output logic      ready_o,
    output logic      ser_clk_o,
    output logic      ser_data_o
);
    localparam int TK_W  = $clog2(TX_HALF + 1);
    localparam int BIT_W = $clog2(CODE_W);

    typedef struct packed {
        logic              busy;
        logic [CODE_W-1:0] sh;
        logic [BIT_W-1:0]  bitn;
        logic [TK_W-1:0]   tick;
        logic              sclk;
        logic              sdat;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (!tx_q.busy) begin
            if (load_i) begin
                tx_d.busy = 1'b1;
                tx_d.sh   = code_i;
                tx_d.sdat = code_i[0];
                tx_d.sclk = 1'b0;
                tx_d.tick = '0;
                tx_d.bitn = '0;
            end
        end else if (tx_q.tick == TK_W'(TX_HALF - 1)) begin
            tx_d.tick = '0;
            if (!tx_q.sclk) begin
                tx_d.sclk = 1'b1;
            end else begin
                tx_d.sclk = 1'b0;
                if (tx_q.bitn == BIT_W'(CODE_W - 1)) begin
                    tx_d.busy = 1'b0;
                    tx_d.sdat = 1'b0;
                end else begin
                    tx_d.bitn = tx_q.bitn + 1'b1;
                    tx_d.sh   = tx_q.sh >> 1;
                    tx_d.sdat = tx_q.sh[1];
                end
            end
        end else begin
            tx_d.tick = tx_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign ready_o    = ~tx_q.busy;
    assign ser_clk_o  = tx_q.sclk;
    assign ser_data_o = tx_q.sdat;

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o)) else $error("data moved while clock high"); // R5
    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ready_o) |=> (!ready_o && !ser_clk_o)) else $error("load did not start frame"); // R5
endmodule

// File: rtl/kbd_serial_rx.sv
module kbd_serial_rx
    import kbd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              rd_i,
    output logic [CODE_W-1:0] byte_o,
    output logic              irq_o,
    output logic              overrun_o
);
    localparam int CNT_W = $clog2(CODE_W);

    typedef struct packed {
        logic              sclk_prev;
        logic [CODE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] held;
        logic              irq;
        logic              ovr;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic rise;
    logic done;

    always_comb begin
        rx_d           = rx_q;
        rx_d.sclk_prev = ser_clk_i;
        rise           = ser_clk_i && !rx_q.sclk_prev;
        done           = 1'b0;
        if (rise) begin
            rx_d.sh = {ser_data_i, rx_q.sh[CODE_W-1:1]};
            if (rx_q.cnt == CNT_W'(CODE_W - 1)) begin
                rx_d.cnt = '0;
                done     = 1'b1;
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
        if (rd_i) begin
            rx_d.irq = 1'b0;
            rx_d.ovr = 1'b0;
        end
        if (done) begin
            rx_d.held = rx_d.sh;
            rx_d.irq  = 1'b1;
            if (rx_q.irq && !rd_i) rx_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign byte_o    = rx_q.held;
    assign irq_o     = rx_q.irq;
    assign overrun_o = rx_q.ovr;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done) |=> (!irq_o && !overrun_o)) else $error("read left flags set"); // R7
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && irq_o && !rd_i) |=> overrun_o) else $error("overrun missed"); // R8
    AST_DONE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq_o) else $error("frame end without interrupt"); // R6
endmodule

// File: rtl/kbd_scan_link.sv
module kbd_scan_link
    import kbd_scan_pkg::*;
#(
    parameter int N_STROBE = 11,
    parameter int N_SENSE  = 8,
    parameter int STEP_DIV = 109091,
    parameter int TX_HALF  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [N_STROBE-1:0] strobe_o,
    input  logic [N_SENSE-1:0]  sense_i,
    output logic                ser_clk_o,
    output logic                ser_data_o,
    input  logic                rd_i,
    output logic [CODE_W-1:0]   rx_byte_o,
    output logic                irq_o,
    output logic                overrun_o
);
    logic      tx_ready;
    logic      code_valid;
    key_code_t code;

    kbd_matrix_scan #(
        .N_STROBE (N_STROBE),
        .N_SENSE  (N_SENSE),
        .STEP_DIV (STEP_DIV)
    ) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .sense_i      (sense_i),
        .tx_ready_i   (tx_ready),
        .strobe_o     (strobe_o),
        .code_valid_o (code_valid),
        .code_o       (code)
    );

    kbd_serial_tx #(
        .TX_HALF (TX_HALF)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (code_valid),
        .code_i     (code),
        .ready_o    (tx_ready),
        .ser_clk_o  (ser_clk_o),
        .ser_data_o (ser_data_o)
    );

    kbd_serial_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk_o),
        .ser_data_i (ser_data_o),
        .rd_i       (rd_i),
        .byte_o     (rx_byte_o),
        .irq_o      (irq_o),
        .overrun_o  (overrun_o)
    );
endmodule

// File: tb/kbd_scan_link_bench.sv
module kbd_scan_link_bench;
    localparam int NS = 11;
    localparam int NK = 8;
    localparam int SD = 8;
    localparam int TH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] strobe;
    logic [NK-1:0] sense;
    logic          ser_clk, ser_data, rd = 1'b0;
    logic [7:0]    rx_byte;
    logic          irq, overrun;

    logic [NK-1:0] keys [NS];
    int            compared = 0;
    int            mismatched = 0;
    int            frames = 0;
    int            cycles = 0;
    logic [7:0]    mon_sh = '0;
    int            mon_n = 0;
    logic [7:0]    last_frame = '0;

    always #2.5 clk = ~clk;

    kbd_scan_link #(.N_STROBE(NS), .N_SENSE(NK), .STEP_DIV(SD), .TX_HALF(TH)) u_kbd_scan_link (
        .clk(clk), .rst_n(rst_n), .strobe_o(strobe), .sense_i(sense),
        .ser_clk_o(ser_clk), .ser_data_o(ser_data), .rd_i(rd),
        .rx_byte_o(rx_byte), .irq_o(irq), .overrun_o(overrun)
    );

    always_comb begin
        sense = '0;
        for (int s = 0; s < NS; s++) if (strobe[s]) sense = keys[s];
    end

    always @(posedge ser_clk) begin
        if (rst_n) begin
            mon_sh = {ser_data, mon_sh[7:1]};
            mon_n  = mon_n + 1;
            if (mon_n == 8) begin
                mon_n      = 0;
                last_frame = mon_sh;
                frames     = frames + 1;
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared = compared + 1;
        if (act !== exp) begin
            mismatched = mismatched + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check({req, " irq"}, irq, 1'b1);
    endtask

    task automatic do_read();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic expect_code(input string req, input logic [7:0] exp);
        wait_irq(req);
        check({req, " rx_byte"}, rx_byte, exp);
        check({req, " serial frame R5"}, last_frame, exp);
        do_read();
        check({req, " read clears R7"}, irq, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 strobe", strobe, 11'd1);
        check("R1 ser_clk", ser_clk, 1'b0);
        check("R1 ser_data", ser_data, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 overrun", overrun, 1'b0);
    endtask

    task automatic t_period();
        int dwell = 0;
        int period = 0;
        while (strobe != 11'd1) @(negedge clk);
        while (strobe == 11'd1) @(negedge clk);
        while (strobe != 11'd1) begin
            @(negedge clk);
            period++;
        end
        while (strobe == 11'd1) begin
            @(negedge clk);
            dwell++;
        end
        check("R2 dwell", dwell, SD);
        check("R2 strobe2", strobe, 11'd2);
        check("R2 pass", period + dwell, NS * SD);
    endtask

    task automatic t_press_release();
        keys[3][5] = 1'b1;
        expect_code("R3 press 3/5", 8'h1D);
        keys[3][5] = 1'b0;
        expect_code("R4 release 3/5", 8'h9D);
    endtask

    task automatic t_idle();
        int f0 = frames;
        repeat (4 * NS * SD) @(negedge clk);
        check("R9 no frame", frames, f0);
        check("R9 irq low", irq, 1'b0);
    endtask

    task automatic t_multi();
        keys[10][1] = 1'b1;
        keys[10][6] = 1'b1;
        expect_code("R10 first lowest", 8'h51);
        expect_code("R10 second", 8'h56);
    endtask

    task automatic t_overrun();
        int f0;
        keys[0][0] = 1'b1;
        wait_irq("R6 first");
        check("R6 byte", rx_byte, 8'h00);
        f0 = frames;
        keys[7][7] = 1'b1;
        while (frames == f0 && cycles < 140000) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R8 byte replaced", rx_byte, 8'h3F);
        check("R8 overrun set", overrun, 1'b1);
        check("R8 irq held", irq, 1'b1);
        do_read();
        check("R8 overrun cleared", overrun, 1'b0);
        check("R7 irq cleared", irq, 1'b0);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) keys[s] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_period();
        t_press_release();
        t_idle();
        t_multi();
        t_overrun();
        summary();
    end
endmodule